// File: doc/BRIEF.md
# Wakeup and Sideband Rule Monitor for an APB5 Link

This block sits passively on one APB5 requester-to-completer connection and watches the wakeup line and the request-side user sideband for rule breaches. It drives no bus signal. It tracks each transfer from its first (setup) cycle to its completion cycle. During that span it holds a snapshot of the request attributes and compares every access cycle against it. It also follows the wakeup line around each transfer, watching when it rises, whether it is held, and whether it was ever seen.

Errors are reported three ways: sticky per-kind flags, a one-cycle one-hot code for the most urgent error of the previous cycle, and a saturating error tally. Two softer conditions are tracked apart from the errors and do not touch them. One is a wakeup pulse that ends with no transfer. The other is a wakeup raised only in the very cycle the transfer starts.

All outputs are registered. A condition present on the inputs during one clock cycle shows at the outputs after the rising edge that ends that cycle. Reset is synchronous and active high.

Top module: `apb_wake_side_mon`

## Requirements
- R1: While reset is high at a rising edge, all error flags, the error code, the error tally, both warning flags and the false-wakeup tally become zero.
- R2: Once a cycle has had both select and wakeup high, wakeup being low in any later cycle up to and including the completion cycle (select, enable and ready all high) raises error bit 0 for that cycle.
- R3: A request-attribute (pauser) value in any access cycle (select and enable high) that differs from its value in the setup cycle (select high, enable low) raises error bit 1. This applies to reads and writes alike.
- R4: On a transfer whose setup cycle had write high, a write-sideband (pwuser) value in an access cycle that differs from its setup value raises error bit 2. On reads the write sideband is ignored.
- R5: An address or direction value in an access cycle that differs from its setup value raises error bit 3.
- R6: When select and enable stay high with ready low for TIMEOUT consecutive cycles, and wakeup has not been high in any of them nor since the current select period began, error bit 4 is raised once in the TIMEOUT-th such cycle. A transfer that saw wakeup never raises it.
- R7: A wakeup pulse that falls in a cycle where select is low, with select low for the whole pulse, sets warning bit 0 and adds one to the false-wakeup tally. It counts as no error.
- R8: Wakeup rising in the setup cycle itself, after being low the cycle before, sets warning bit 1. It counts as no error.
- R9: Error flags (bit 0 wake drop, 1 pauser, 2 pwuser, 3 address/direction, 4 deadlock) stay set until reset.
- R10: The error code is one-hot and shows, for one cycle, the lowest-numbered error bit raised in the previous cycle. It is zero after a cycle with no error.
- R11: The error tally adds the number of error bits raised in each cycle and saturates at its maximum (255 for the default 8 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | Transfer direction, 1 = write |
| pready | input | 1 | Completer ready |
| paddr | input | ADDR_W | Transfer address |
| pwakeup | input | 1 | Wakeup line from the requester |
| pauser | input | AUSER_W | Request user sideband |
| pwuser | input | WUSER_W | Write-data user sideband |
| err_flags | output | 5 | Sticky error flags, bit order as in R9 |
| err_code | output | 5 | One-hot code of the previous cycle's top-priority error |
| err_count | output | CNT_W | Saturating error tally |
| warn_flags | output | 2 | Sticky warnings: bit 0 false wakeup, bit 1 late wakeup |
| false_wake_count | output | CNT_W | Saturating false-wakeup tally |

## Verification
The embedded assertions check, every cycle, that the error flags never clear, that the code is one-hot and matches a set flag, that the tally holds at saturation and is frozen in cycles with no error, and that the stall counter stays within TIMEOUT. Whether each breach is caught in the right cycle, with the right priority and count, can only be shown by the bench. The same holds for the deadlock timing at TIMEOUT-1 versus TIMEOUT stalled cycles, for read transfers ignoring the write sideband, and for warnings leaving the error state untouched. A randomized run of legal transfers, with random wait states and with the write sideband scrambled on reads, must leave every flag and tally at zero.

// File: rtl/wsmon_pkg.sv
package wsmon_pkg;

    localparam int ERR_N  = 5;
    localparam int WARN_N = 2;

    // Error events; the last member is bit 0, which is also the top priority.
    typedef struct packed {
        logic deadlock;
        logic addr_ctrl;
        logic wuser;
        logic auser;
        logic wake_drop;
    } err_ev_t;

    typedef struct packed {
        logic late_wake;
        logic false_wake;
    } warn_ev_t;

    // Bus phase decode of one cycle.
    typedef struct packed {
        logic setup;
        logic access;
        logic stall;
        logic done;
    } phase_t;

    function automatic phase_t decode_phase(logic sel, logic en, logic rdy);
        phase_t p;
        p.setup  = sel & ~en;
        p.access = sel & en;
        p.stall  = sel & en & ~rdy;
        p.done   = sel & en & rdy;
        return p;
    endfunction

    function automatic logic [ERR_N-1:0] lowest_one(logic [ERR_N-1:0] v);
        return v & (~v + 1'b1);
    endfunction

    function automatic logic [2:0] ones_in(logic [ERR_N-1:0] v);
        logic [2:0] n;
        n = '0;
        for (int i = 0; i < ERR_N; i++) begin
            n = n + {2'b00, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/wsmon_hold_cmp.sv
module wsmon_hold_cmp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         check,
    input  logic [W-1:0] data,
    output logic         differs
);
    logic [W-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
        end else if (capture) begin
            ref_q <= data;
        end
    end

    assign differs = check & (data != ref_q);

endmodule

// File: rtl/wsmon_wake.sv
module wsmon_wake
    import wsmon_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   psel,
    input  logic   pwakeup,
    input  phase_t ph,
    output logic   ev_drop,
    output logic   ev_dead,
    output logic   ev_false,
    output logic   ev_late
);
    localparam int SW = $clog2(TIMEOUT + 1);
    localparam logic [SW-1:0] LIMIT = SW'(TIMEOUT);

    logic          bound_q;     // wakeup and select seen together, transfer open
    logic          seen_q;      // wakeup seen in this select period
    logic          pw_q;        // wakeup one cycle ago
    logic          had_sel_q;   // select seen during the current wakeup pulse
    logic [SW-1:0] stall_q;
    logic          stall_nowake;

    assign stall_nowake = ph.stall & ~(seen_q | pwakeup);
    assign ev_drop  = bound_q & ~pwakeup;
    assign ev_dead  = stall_nowake & (stall_q == LIMIT - 1'b1);
    assign ev_false = pw_q & ~pwakeup & ~had_sel_q & ~psel;
    assign ev_late  = ph.setup & pwakeup & ~pw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_q   <= 1'b0;
            seen_q    <= 1'b0;
            pw_q      <= 1'b0;
            had_sel_q <= 1'b0;
            stall_q   <= '0;
        end else begin
            bound_q   <= (bound_q | (psel & pwakeup)) & ~ph.done;
            if (ph.done)       seen_q <= 1'b0;
            else if (pwakeup)  seen_q <= 1'b1;
            else if (!psel)    seen_q <= 1'b0;
            pw_q      <= pwakeup;
            had_sel_q <= pwakeup & (had_sel_q | psel);
            if (!stall_nowake)         stall_q <= '0;
            else if (stall_q != LIMIT) stall_q <= stall_q + 1'b1;
        end
    end

    assert_stall_limit_R6: assert property (@(posedge clk) disable iff (rst)
        stall_q <= LIMIT);
    assert_dead_needs_stall_R6: assert property (@(posedge clk) disable iff (rst)
        ev_dead |-> (psel && !pwakeup));
    assert_late_in_setup_R8: assert property (@(posedge clk) disable iff (rst)
        ev_late |-> (psel && pwakeup));

endmodule

// File: rtl/wsmon_accum.sv
module wsmon_accum
    import wsmon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  err_ev_t           err_ev,
    input  warn_ev_t          warn_ev,
    output logic [ERR_N-1:0]  err_flags,
    output logic [ERR_N-1:0]  err_code,
    output logic [CNT_W-1:0]  err_count,
    output logic [WARN_N-1:0] warn_flags,
    output logic [CNT_W-1:0]  false_wake_count
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] a, logic [2:0] inc);
        logic [CNT_W+3:0] s;
        s = {4'b0000, a} + {{(CNT_W+1){1'b0}}, inc};
        return (s > {4'b0000, CMAX}) ? CMAX : s[CNT_W-1:0];
    endfunction

    logic [ERR_N-1:0] ev_vec;
    assign ev_vec = err_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flags        <= '0;
            err_code         <= '0;
            err_count        <= '0;
            warn_flags       <= '0;
            false_wake_count <= '0;
        end else begin
            err_flags  <= err_flags | ev_vec;
            err_code   <= lowest_one(ev_vec);
            err_count  <= sat_add(err_count, ones_in(ev_vec));
            warn_flags <= warn_flags | warn_ev;
            if (warn_ev.false_wake) begin
                false_wake_count <= sat_add(false_wake_count, 3'd1);
            end
        end
    end

    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (err_flags != '0) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
    assert_code_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err_code));
    assert_code_has_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (err_code != '0) |-> ((err_code & err_flags) == err_code));
    assert_count_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (err_count == CMAX) |=> (err_count == CMAX));
    assert_count_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (err_code == '0) |-> $stable(err_count));

endmodule

// File: rtl/apb_wake_side_mon.sv
module apb_wake_side_mon
    import wsmon_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int AUSER_W = 16,
    parameter int WUSER_W = 8,
    parameter int TIMEOUT = 64,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic               pready,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic               pwakeup,
    input  logic [AUSER_W-1:0] pauser,
    input  logic [WUSER_W-1:0] pwuser,
    output logic [4:0]         err_flags,
    output logic [4:0]         err_code,
    output logic [CNT_W-1:0]   err_count,
    output logic [1:0]         warn_flags,
    output logic [CNT_W-1:0]   false_wake_count
);
    phase_t   ph;
    logic     open_q;
    logic     wr_ref_q;
    logic     chk;
    err_ev_t  err_ev;
    warn_ev_t warn_ev;

    assign ph  = decode_phase(psel, penable, pready);
    assign chk = ph.access & open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            wr_ref_q <= 1'b0;
        end else begin
            if (ph.setup)     open_q <= 1'b1;
            else if (ph.done) open_q <= 1'b0;
            if (ph.setup)     wr_ref_q <= pwrite;
        end
    end

    wsmon_hold_cmp #(.W(ADDR_W + 1)) u_cmp_addr (
        .clk(clk), .rst(rst), .capture(ph.setup), .check(chk),
        .data({paddr, pwrite}), .differs(err_ev.addr_ctrl));

    wsmon_hold_cmp #(.W(AUSER_W)) u_cmp_auser (
        .clk(clk), .rst(rst), .capture(ph.setup), .check(chk),
        .data(pauser), .differs(err_ev.auser));

    wsmon_hold_cmp #(.W(WUSER_W)) u_cmp_wuser (
        .clk(clk), .rst(rst), .capture(ph.setup), .check(chk & wr_ref_q),
        .data(pwuser), .differs(err_ev.wuser));

    wsmon_wake #(.TIMEOUT(TIMEOUT)) u_wake (
        .clk(clk), .rst(rst), .psel(psel), .pwakeup(pwakeup), .ph(ph),
        .ev_drop(err_ev.wake_drop), .ev_dead(err_ev.deadlock),
        .ev_false(warn_ev.false_wake), .ev_late(warn_ev.late_wake));

    wsmon_accum #(.CNT_W(CNT_W)) u_accum (
        .clk(clk), .rst(rst), .err_ev(err_ev), .warn_ev(warn_ev),
        .err_flags(err_flags), .err_code(err_code), .err_count(err_count),
        .warn_flags(warn_flags), .false_wake_count(false_wake_count));

    assert_wuser_read_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (open_q && !wr_ref_q) |-> !err_ev.wuser);
    assert_no_check_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !psel |=> ((err_code & 5'b01110) == 5'b00000));

endmodule

// File: tb/apb_wake_side_mon_tb_top.sv
module apb_wake_side_mon_tb_top;
    localparam int AW = 32, UAW = 16, UWW = 8, TO = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst, psel, penable, pwrite, pready, pwakeup;
    logic [AW-1:0]  paddr;
    logic [UAW-1:0] pauser;
    logic [UWW-1:0] pwuser;
    logic [4:0] err_flags, err_code;
    logic [7:0] err_count, false_wake_count;
    logic [1:0] warn_flags;

    int checks = 0, errors = 0;
    int exp_cnt = 0;

    apb_wake_side_mon #(.ADDR_W(AW), .AUSER_W(UAW), .WUSER_W(UWW), .TIMEOUT(TO)) dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .pready(pready), .paddr(paddr), .pwakeup(pwakeup), .pauser(pauser),
        .pwuser(pwuser), .err_flags(err_flags), .err_code(err_code),
        .err_count(err_count), .warn_flags(warn_flags),
        .false_wake_count(false_wake_count));

    function automatic logic [4:0] exp_code(logic [4:0] raised);
        for (int i = 0; i < 5; i++) if (raised[i]) return 5'(1 << i);
        return 5'b0;
    endfunction

    function automatic int sat8(int a, int add);
        return (a + add > 255) ? 255 : a + add;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(logic s, logic e, logic r);
        psel = s; penable = e; pready = r;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h1d5eed);
        rst = 1'b1; bus(0, 0, 0); pwrite = 0; pwakeup = 0;
        paddr = '0; pauser = '0; pwuser = '0;
        cyc(3);
        rst = 1'b0;
        cyc();
        chk("R1 flags", 32'(err_flags), 0);
        chk("R1 code", 32'(err_code), 0);
        chk("R1 count", 32'(err_count), 0);
        chk("R1 warn", 32'(warn_flags), 0);
        chk("R1 fwcount", 32'(false_wake_count), 0);

        // Random legal transfers; reads scramble the write sideband (R4 ignore).
        for (int t = 0; t < 150; t++) begin
            int w;
            w = $urandom_range(0, 3);
            pwakeup = 1; cyc();
            paddr = $urandom; pwrite = 1'($urandom); pauser = 16'($urandom); pwuser = 8'($urandom);
            bus(1, 0, 0); cyc();
            bus(1, 1, 0);
            for (int k = 0; k < w; k++) begin
                if (!pwrite) pwuser = 8'($urandom);
                cyc();
            end
            bus(1, 1, 1); cyc();
            bus(0, 0, 0); pwakeup = 0; paddr = $urandom; pauser = 16'($urandom);
            cyc($urandom_range(1, 2));
        end
        chk("R2-legal R4-read-ignore flags", 32'(err_flags), 0);
        chk("R11 count after legal", 32'(err_count), 32'(exp_cnt));
        chk("R7 no false on legal", 32'(false_wake_count), 0);

        // R8: wakeup rises in the setup cycle.
        paddr = 32'h40; pwrite = 0; pauser = 16'h1; pwakeup = 1; bus(1, 0, 0); cyc();
        chk("R8 late warn", 32'(warn_flags), 32'h2);
        bus(1, 1, 1); cyc();
        bus(0, 0, 0); pwakeup = 0; cyc();
        chk("R8 no error", 32'(err_count), 32'(exp_cnt));

        // R7: pulse without a transfer.
        pwakeup = 1; cyc(3);
        chk("R7 no warn yet", 32'(false_wake_count), 0);
        pwakeup = 0; cyc();
        chk("R7 warn flag", 32'(warn_flags), 32'h3);
        chk("R7 fw count", 32'(false_wake_count), 1);
        chk("R7 no error", 32'(err_flags), 0);

        // R4: write sideband changes in a write wait cycle.
        pwakeup = 1; cyc();
        paddr = 32'h80; pwrite = 1; pwuser = 8'h5A; bus(1, 0, 0); cyc();
        pwuser = 8'hA5; bus(1, 1, 0); cyc();
        exp_cnt = sat8(exp_cnt, 1);
        chk("R4 code", 32'(err_code), 32'(exp_code(5'b00100)));
        chk("R4 flag", 32'(err_flags), 32'h04);
        chk("R11 count", 32'(err_count), 32'(exp_cnt));
        pwuser = 8'h5A; bus(1, 1, 1); cyc();
        chk("R10 code clears", 32'(err_code), 0);
        bus(0, 0, 0); pwakeup = 0; cyc();

        // R3: request sideband changes on a read.
        pwakeup = 1; cyc();
        pwrite = 0; pauser = 16'h1111; bus(1, 0, 0); cyc();
        pauser = 16'h2222; bus(1, 1, 0); cyc();
        exp_cnt = sat8(exp_cnt, 1);
        chk("R3 code", 32'(err_code), 32'(exp_code(5'b00010)));
        pauser = 16'h1111; bus(1, 1, 1); cyc();
        bus(0, 0, 0); pwakeup = 0; cyc();
        chk("R3 R9 flags", 32'(err_flags), 32'h06);

        // R5: address changes in the completion cycle.
        pwakeup = 1; cyc();
        paddr = 32'h100; bus(1, 0, 0); cyc();
        paddr = 32'h104; bus(1, 1, 1); cyc();
        exp_cnt = sat8(exp_cnt, 1);
        chk("R5 code", 32'(err_code), 32'(exp_code(5'b01000)));
        bus(0, 0, 0); pwakeup = 0; cyc();
        chk("R5 R9 flags", 32'(err_flags), 32'h0E);
        chk("R11 count", 32'(err_count), 32'(exp_cnt));

        // R2 + R10 priority: wakeup drops with a sideband change in the same cycle.
        paddr = 32'h200; pauser = 16'hAAAA; pwakeup = 1; bus(1, 0, 0); cyc();
        pwakeup = 0; pauser = 16'hBBBB; bus(1, 1, 0); cyc();
        exp_cnt = sat8(exp_cnt, 2);
        chk("R10 priority code", 32'(err_code), 32'(exp_code(5'b00011)));
        chk("R2 R11 count", 32'(err_count), 32'(exp_cnt));
        pauser = 16'hAAAA; bus(1, 1, 1); cyc();
        exp_cnt = sat8(exp_cnt, 1);
        chk("R2 drop at completion", 32'(err_code), 32'(exp_code(5'b00001)));
        bus(0, 0, 0); cyc();
        chk("R2 count", 32'(err_count), 32'(exp_cnt));

        // R6: long stall with wakeup held is not a deadlock.
        pwakeup = 1; cyc();
        bus(1, 0, 0); cyc();
        bus(1, 1, 0); cyc(100);
        chk("R6 no deadlock when woken", 32'(err_flags[4]), 0);
        bus(1, 1, 1); cyc();
        bus(0, 0, 0); pwakeup = 0; cyc(2);
        chk("R6 count unchanged", 32'(err_count), 32'(exp_cnt));

        // R6: stall with no wakeup.
        bus(1, 0, 0); cyc();
        bus(1, 1, 0); cyc(TO - 1);
        chk("R6 not yet", 32'(err_flags[4]), 0);
        cyc();
        exp_cnt = sat8(exp_cnt, 1);
        chk("R6 deadlock code", 32'(err_code), 32'(exp_code(5'b10000)));
        cyc(5);
        chk("R6 fires once", 32'(err_count), 32'(exp_cnt));
        bus(1, 1, 1); cyc();
        bus(0, 0, 0); cyc();

        // R11 saturation and R9 stickiness.
        pwakeup = 1; cyc();
        pwrite = 1; pauser = 16'h0F0F; bus(1, 0, 0); cyc();
        pauser = 16'hF0F0; bus(1, 1, 0); cyc(300);
        exp_cnt = sat8(exp_cnt, 300);
        chk("R11 saturated", 32'(err_count), 32'(exp_cnt));
        pauser = 16'h0F0F; bus(1, 1, 1); cyc();
        bus(0, 0, 0); pwakeup = 0; cyc();
        chk("R10 idle code", 32'(err_code), 0);
        chk("R9 all sticky", 32'(err_flags), 32'h1F);
        chk("R11 still saturated", 32'(err_count), 255);

        // R1: reset clears everything.
        rst = 1'b1; cyc(2); rst = 1'b0; cyc();
        chk("R1 flags after reset", 32'(err_flags), 0);
        chk("R1 count after reset", 32'(err_count), 0);
        chk("R1 warn after reset", 32'({warn_flags, false_wake_count}), 0);

        summary();
        $finish;
    end
endmodule